// File: doc/BRIEF.md
# Indirect Register Window Controller

This block gives a processor a small memory-mapped port into the register file of an interrupt routing controller. Three byte offsets are decoded from the low eight address bits: a select register at 0x00, a data window at 0x10 and an end-of-interrupt (EOI) register at 0x40. The select value picks what the window reaches. Index 0x00 is the identification register, 0x01 the version register and 0x02 the arbitration register. Starting at 0x10, each 64-bit routing entry takes two consecutive select values: the even one for its low 32 bits and the odd one for its high 32 bits.

Routing entries keep the common field layout that the delivery logic decodes. Bits 7:0 hold the vector and bit 12 is the delivery-busy flag. Bit 14 is the remote-acknowledge-pending flag, bit 15 is the trigger mode (1 = level, 0 = edge) and bit 16 is the mask. Bits 12 and 14 are owned by the delivery side through set, clear and busy inputs, and a processor write cannot change them. After every accepted entry write the block raises a one-cycle rescan request so the delivery logic re-examines the table. A 32-bit write to the EOI offset is forwarded as a one-cycle vector pulse, but only when the block is built as version 0x20.

One request per cycle is accepted. A small output-phase machine has four states. IDLE is entered after reset, after an idle cycle and after a write that triggers nothing. RDATA is entered after any read and presents `rsp_valid` with the read data. RESCAN is entered after an accepted entry write. EOI is entered after a forwarded EOI write. Each state lasts exactly one cycle. The next state depends only on the request seen in the current cycle.

Top module: `indreg_window`

## Requirements
- R1: Only `req_addr[7:0]` is decoded. A read at any offset gives `rsp_valid` = 1 and the data on `rsp_rdata` in the cycle after the request. Writes never raise `rsp_valid`. Offset 0x00 reads back the select value, and a write there loads `req_wdata[7:0]` for any size. Offsets other than 0x00 and 0x10 read as zero.
- R2: Window reads and writes, and EOI writes, take effect only when `req_size` = 4 (bytes). A window read of another size returns zero. A write of another size changes nothing and raises no pulse.
- R3: Select 0x00 and 0x02 both read the 4-bit ID at bits 27:24. A write at select 0x00 stores `req_wdata[27:24]`. Writes at selects 0x01 and 0x02 are discarded.
- R4: Select 0x01 reads `{8'h00, NPINS-1, 8'h00, VERSION}`.
- R5: Entry N is at select 0x10+2N (bits 31:0) and 0x10+2N+1 (bits 63:32). Selects 0x03 to 0x0F and those past the last entry read zero and accept no write.
- R6: An entry write replaces only the addressed half. Bits 12 and 14 keep the values they had before the write.
- R7: If bit 15 of the entry is 0 after an entry write, bit 14 of that entry is cleared.
- R8: Each accepted entry write raises `rescan_req` for exactly the following cycle. Nothing else raises it.
- R9: With VERSION 0x20, a 4-byte write at offset 0x40 gives `eoi_valid` = 1 and `eoi_vector` = `req_wdata[7:0]` in the next cycle. With VERSION 0x11, `eoi_valid` never rises. At most one of `rsp_valid`, `rescan_req` and `eoi_valid` is high in any cycle.
- R10: After reset every entry is 64'h0000_0000_0001_0000 (mask only), and the select and ID are zero.
- R11: Each cycle, bit 14 of entry i becomes (bit14 | `irr_set[i]`) & ~`irr_clr[i]`, and bit 12 takes `dlv_busy[i]`. A same-cycle entry write applies after this update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irr_set | input | NPINS | Set remote-pending flag per entry |
| irr_clr | input | NPINS | Clear remote-pending flag per entry |
| dlv_busy | input | NPINS | Delivery-busy status per entry |
| rescan_req | output | 1 | One-cycle rescan request after an entry write |
| eoi_valid | output | 1 | One-cycle EOI pulse |
| eoi_vector | output | 8 | EOI vector |

## Verification
Every result is due exactly one clock edge after the request that causes it. This holds for read data with `rsp_valid`, for `rescan_req` and for the EOI pulse. A table or ID update is visible to a read issued in the next cycle, so its data appears two edges after the write. The bench drives a request at a falling edge and advances its reference model by that one request. It then compares all outputs at the next falling edge, so each expected value lands in the cycle it is due. Status inputs are applied in the same model step before the request, which matches the ordering in R11.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam logic [7:0] OFF_SEL  = 8'h00;
    localparam logic [7:0] OFF_WIN  = 8'h10;
    localparam logic [7:0] OFF_EOI  = 8'h40;

    localparam logic [7:0] REG_ID   = 8'h00;
    localparam logic [7:0] REG_VER  = 8'h01;
    localparam logic [7:0] REG_ARB  = 8'h02;
    localparam logic [7:0] TBL_BASE = 8'h10;

    localparam int BIT_DLV  = 12;
    localparam int BIT_IRR  = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;
    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;

    localparam logic [63:0] RO_MASK     = (64'd1 << BIT_DLV) | (64'd1 << BIT_IRR);
    localparam logic [63:0] ENTRY_RESET = 64'd1 << BIT_MASK;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RDATA  = 2'd1,
        PH_RESCAN = 2'd2,
        PH_EOI    = 2'd3
    } phase_e;
endpackage

// File: rtl/irw_entry_merge.sv
module irw_entry_merge
    import irw_pkg::*;
(
    input  logic [63:0] cur,
    input  logic        wr_hi,
    input  logic [31:0] wr_data,
    output logic [63:0] nxt
);
    logic [63:0] raw;

    always_comb begin
        raw = wr_hi ? {wr_data, cur[31:0]} : {cur[63:32], wr_data};
        nxt = (raw & ~RO_MASK) | (cur & RO_MASK);
        if (!nxt[BIT_TRIG]) begin
            nxt[BIT_IRR] = 1'b0;
        end
    end
endmodule

// File: rtl/irw_entry_table.sv
module irw_entry_table
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_hi,
    input  logic [31:0]             wr_data,
    input  logic [NPINS-1:0]        irr_set,
    input  logic [NPINS-1:0]        irr_clr,
    input  logic [NPINS-1:0]        dlv_busy,
    output logic [NPINS-1:0][63:0]  entries
);
    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic [63:0] stat;
        logic [63:0] merged;
        logic        hit;

        always_comb begin
            stat           = entries[g];
            stat[BIT_IRR]  = (entries[g][BIT_IRR] | irr_set[g]) & ~irr_clr[g];
            stat[BIT_DLV]  = dlv_busy[g];
            hit            = wr_en && (wr_idx == IDX_W'(g));
        end

        irw_entry_merge u_merge (
            .cur     (stat),
            .wr_hi   (wr_hi),
            .wr_data (wr_data),
            .nxt     (merged)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= ENTRY_RESET;
            end else begin
                entries[g] <= hit ? merged : stat;
            end
        end
    end
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
    import irw_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter int         IDX_W   = 5,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic [7:0]             off,
    input  logic                   word_ok,
    input  logic [7:0]             sel,
    input  logic                   in_range,
    input  logic [IDX_W-1:0]       idx,
    input  logic [ID_W-1:0]        id,
    input  logic [NPINS-1:0][63:0] entries,
    output logic [31:0]            rd
);
    localparam logic [7:0] MAX_ENT = 8'(NPINS - 1);

    logic [63:0] ent;

    always_comb begin
        ent = entries[idx];
        rd  = '0;
        if (off == OFF_SEL) begin
            rd = {24'd0, sel};
        end else if (off == OFF_WIN && word_ok) begin
            if (sel == REG_ID || sel == REG_ARB) begin
                rd = {4'd0, id, 24'd0};
            end else if (sel == REG_VER) begin
                rd = {8'd0, MAX_ENT, 8'd0, VERSION};
            end else if (in_range) begin
                rd = sel[0] ? ent[63:32] : ent[31:0];
            end
        end
    end
endmodule

// File: rtl/indreg_window.sv
module indreg_window
    import irw_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic [NPINS-1:0]  irr_set,
    input  logic [NPINS-1:0]  irr_clr,
    input  logic [NPINS-1:0]  dlv_busy,
    output logic              rescan_req,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);
    localparam int IDX_W    = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int SEL_LAST = int'(TBL_BASE) + 2 * NPINS - 1;
    localparam bit HAS_EOI  = (VERSION == 8'h20);

    if (VERSION != 8'h11 && VERSION != 8'h20) begin : g_bad_version
        $error("indreg_window: VERSION must be 8'h11 or 8'h20");
    end
    if (SEL_LAST > 255) begin : g_bad_npins
        $error("indreg_window: NPINS too large for an 8-bit select");
    end

    logic [7:0]             off;
    logic                   word_ok;
    logic [7:0]             sel_q;
    logic [ID_W-1:0]        id_q;
    logic                   in_range;
    logic [7:0]             rel;
    logic [IDX_W-1:0]       idx;
    logic                   wr_req;
    logic                   win_wr;
    logic                   ent_wr;
    logic                   eoi_fire;
    logic [31:0]            rd_comb;
    logic [31:0]            rdata_q;
    logic [7:0]             evec_q;
    logic [NPINS-1:0][63:0] tbl_q;
    phase_e                 phase_q;
    phase_e                 phase_d;
    logic                   unused_addr;

    assign unused_addr = ^req_addr;

    always_comb begin
        off      = req_addr[7:0];
        word_ok  = (req_size == 3'd4);
        in_range = (int'(sel_q) >= int'(TBL_BASE)) && (int'(sel_q) <= SEL_LAST);
        rel      = sel_q - TBL_BASE;
        idx      = IDX_W'(rel >> 1);
        wr_req   = req_valid && req_write;
        win_wr   = wr_req && (off == OFF_WIN) && word_ok;
        ent_wr   = win_wr && in_range;
        eoi_fire = wr_req && (off == OFF_EOI) && word_ok && HAS_EOI;
    end

    irw_read_mux #(.NPINS(NPINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rmux (
        .off      (off),
        .word_ok  (word_ok),
        .sel      (sel_q),
        .in_range (in_range),
        .idx      (idx),
        .id       (id_q),
        .entries  (tbl_q),
        .rd       (rd_comb)
    );

    irw_entry_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ent_wr),
        .wr_idx   (idx),
        .wr_hi    (sel_q[0]),
        .wr_data  (req_wdata),
        .irr_set  (irr_set),
        .irr_clr  (irr_clr),
        .dlv_busy (dlv_busy),
        .entries  (tbl_q)
    );

    // Next output phase from the current request
    always_comb begin
        phase_d = PH_IDLE;
        if (req_valid) begin
            if (!req_write) begin
                phase_d = PH_RDATA;
            end else if (ent_wr) begin
                phase_d = PH_RESCAN;
            end else if (eoi_fire) begin
                phase_d = PH_EOI;
            end
        end
    end

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sel_q   <= '0;
            id_q    <= '0;
            rdata_q <= '0;
            evec_q  <= '0;
        end else begin
            phase_q <= phase_d;
            rdata_q <= (req_valid && !req_write) ? rd_comb : 32'd0;
            evec_q  <= eoi_fire ? req_wdata[7:0] : 8'd0;
            if (wr_req && off == OFF_SEL) begin
                sel_q <= req_wdata[7:0];
            end
            if (win_wr && sel_q == REG_ID) begin
                id_q <= req_wdata[ID_LSB +: ID_W];
            end
        end
    end

    // Outputs decoded from the phase
    always_comb begin
        rsp_valid  = 1'b0;
        rescan_req = 1'b0;
        eoi_valid  = 1'b0;
        unique case (phase_q)
            PH_IDLE:   ;
            PH_RDATA:  rsp_valid  = 1'b1;
            PH_RESCAN: rescan_req = 1'b1;
            PH_EOI:    eoi_valid  = 1'b1;
        endcase
        rsp_rdata  = rdata_q;
        eoi_vector = evec_q;
    end
endmodule

// File: rtl/indreg_window_chk.sv
module indreg_window_chk
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [7:0]             off,
    input logic [2:0]             req_size,
    input logic [31:0]            req_wdata,
    input logic                   rsp_valid,
    input logic                   rescan_req,
    input logic                   eoi_valid,
    input logic [7:0]             eoi_vector,
    input logic [7:0]             sel,
    input logic [NPINS-1:0][63:0] entries
);
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       rel;

    assign rel = sel - TBL_BASE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx <= '0;
        end else if (req_valid && req_write && off == OFF_WIN) begin
            last_idx <= IDX_W'(rel >> 1);
        end
    end

    assert_read_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_write_no_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    assert_short_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 3'd4) |=> (!rescan_req && !eoi_valid));

    assert_edge_clears_irr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rescan_req |-> !(entries[last_idx][BIT_IRR] && !entries[last_idx][BIT_TRIG]));

    assert_rescan_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rescan_req |-> $past(req_valid && req_write && off == OFF_WIN && req_size == 3'd4));

    assert_eoi_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_vector == $past(req_wdata[7:0])));

    assert_eoi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(req_valid && req_write && off == OFF_EOI && req_size == 3'd4));

    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rescan_req, eoi_valid}));
endmodule

bind indreg_window indreg_window_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .off        (req_addr[7:0]),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rescan_req (rescan_req),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .sel        (sel_q),
    .entries    (tbl_q)
);

// File: tb/indreg_window_tb.sv
`timescale 1ns/1ps
module indreg_window_tb_top;
    localparam int NP = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [2:0]      req_size = 3'd4;
    logic [31:0]     req_wdata = '0;
    logic [NP-1:0]   irr_set = '0;
    logic [NP-1:0]   irr_clr = '0;
    logic [NP-1:0]   dlv_busy = '0;
    logic            rsp_valid, rescan_req, eoi_valid;
    logic [31:0]     rsp_rdata;
    logic [7:0]      eoi_vector;
    logic            v11_rsp, v11_rescan, v11_eoi;
    logic [31:0]     v11_rdata;
    logic [7:0]      v11_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit [63:0] m_ent [NP];
    bit [7:0]  m_sel;
    bit [3:0]  m_id;
    bit        e_rv, e_rs, e_ev;
    bit [31:0] e_rd;
    bit [7:0]  e_vec;

    always #5 clk = ~clk;

    indreg_window #(.NPINS(NP), .VERSION(8'h20), .ADDR_W(12)) dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .rsp_valid, .rsp_rdata, .irr_set, .irr_clr, .dlv_busy,
        .rescan_req, .eoi_valid, .eoi_vector
    );

    indreg_window #(.NPINS(NP), .VERSION(8'h11), .ADDR_W(12)) dut_v11 (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .rsp_valid(v11_rsp), .rsp_rdata(v11_rdata), .irr_set, .irr_clr, .dlv_busy,
        .rescan_req(v11_rescan), .eoi_valid(v11_eoi), .eoi_vector(v11_vec)
    );

    task automatic model_reset();
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h1_0000;
        m_sel = 0; m_id = 0;
        e_rv = 0; e_rs = 0; e_ev = 0; e_rd = 0; e_vec = 0;
    endtask

    // Advance the reference by the request now on the inputs
    task automatic model_step();
        bit [7:0] off = req_addr[7:0];
        bit ok = (req_size == 3'd4);
        int s = m_sel;
        bit inr = (s >= 16) && (s < 16 + 2 * NP);
        int ix = inr ? (s - 16) / 2 : 0;
        bit [63:0] nw;
        e_rv = req_valid && !req_write;
        e_rd = 0; e_rs = 0; e_ev = 0; e_vec = 0;
        if (e_rv) begin
            if (off == 8'h00) e_rd = {24'd0, m_sel};
            else if (off == 8'h10 && ok) begin
                if (s == 0 || s == 2) e_rd = {4'd0, m_id, 24'd0};
                else if (s == 1) e_rd = {8'd0, 8'(NP - 1), 8'd0, 8'h20};
                else if (inr) e_rd = (s % 2 == 1) ? m_ent[ix][63:32] : m_ent[ix][31:0];
            end
        end
        for (int i = 0; i < NP; i++) begin
            m_ent[i][14] = (m_ent[i][14] | irr_set[i]) & ~irr_clr[i];
            m_ent[i][12] = dlv_busy[i];
        end
        if (req_valid && req_write) begin
            if (off == 8'h00) m_sel = req_wdata[7:0];
            else if (off == 8'h10 && ok) begin
                if (s == 0) m_id = req_wdata[27:24];
                else if (inr) begin
                    nw = m_ent[ix];
                    if (s % 2 == 1) nw[63:32] = req_wdata; else nw[31:0] = req_wdata;
                    nw[12] = m_ent[ix][12];
                    nw[14] = m_ent[ix][14];
                    if (!nw[15]) nw[14] = 0;
                    m_ent[ix] = nw;
                    e_rs = 1;
                end
            end else if (off == 8'h40 && ok) begin
                e_ev = 1; e_vec = req_wdata[7:0];
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (rsp_valid !== e_rv || rsp_rdata !== e_rd || rescan_req !== e_rs ||
            eoi_valid !== e_ev || eoi_vector !== e_vec || v11_eoi !== 1'b0) begin
            fails++;
            $display("FAIL %s: got rv=%0b rd=%h rs=%0b ev=%0b vec=%h v11ev=%0b exp rv=%0b rd=%h rs=%0b ev=%0b vec=%h v11ev=0",
                     tag, rsp_valid, rsp_rdata, rescan_req, eoi_valid, eoi_vector, v11_eoi,
                     e_rv, e_rd, e_rs, e_ev, e_vec);
        end
    endtask

    task automatic tick(string tag);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(input bit [11:0] a, input bit [2:0] sz, input string tag);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_wdata = 0;
        tick(tag);
        req_valid = 0;
    endtask

    task automatic wr(input bit [11:0] a, input bit [2:0] sz, input bit [31:0] d, input string tag);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        tick(tag);
        req_valid = 0;
    endtask

    task automatic idle(input string tag);
        req_valid = 0; req_write = 0;
        tick(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R10 outputs in reset");
        rst_n = 1;
        rd(12'h000, 3'd4, "R10 select resets to zero");
        wr(12'h000, 3'd4, 32'h10, "R1 select write");
        rd(12'h010, 3'd4, "R10 entry0 low resets to mask only");
        wr(12'h000, 3'd1, 32'h3F, "R1 select write size 1");
        rd(12'h010, 3'd4, "R10 last entry high resets to zero");
        // ID, arbitration, version
        wr(12'h000, 3'd4, 32'h00, "R3 select id");
        wr(12'h010, 3'd4, 32'hA5FF_FFFF, "R3 id write");
        rd(12'h010, 3'd4, "R3 id read masked");
        rd(12'hF10, 3'd4, "R1 upper address bits ignored");
        wr(12'h000, 3'd4, 32'h02, "R3 select arb");
        wr(12'h010, 3'd4, 32'h0C00_0000, "R3 arb write discarded");
        rd(12'h010, 3'd4, "R3 arb reads id");
        wr(12'h000, 3'd4, 32'h01, "R4 select version");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R3 version write discarded");
        rd(12'h010, 3'd4, "R4 version read");
        rd(12'h020, 3'd4, "R1 unmapped offset reads zero");
        rd(12'h040, 3'd4, "R1 eoi offset reads zero");
        // Entry 0 writes
        wr(12'h000, 3'd4, 32'h10, "R5 select entry0 low");
        wr(12'h010, 3'd2, 32'h0000_8031, "R2 short window write ignored");
        rd(12'h010, 3'd2, "R2 short window read zero");
        rd(12'h010, 3'd4, "R2 entry unchanged");
        wr(12'h010, 3'd4, 32'h0000_8031, "R8 level entry write rescan");
        rd(12'h010, 3'd4, "R6 low half written");
        wr(12'h000, 3'd4, 32'h11, "R5 select entry0 high");
        wr(12'h010, 3'd4, 32'hFF00_0000, "R6 high half write");
        rd(12'h010, 3'd4, "R6 high half read");
        wr(12'h000, 3'd4, 32'h10, "R5 select entry0 low again");
        rd(12'h010, 3'd4, "R6 low half kept by high write");
        // Status bits from delivery side
        irr_set[0] = 1; dlv_busy[0] = 1;
        idle("R11 set remote pending and busy");
        irr_set[0] = 0;
        rd(12'h010, 3'd4, "R11 status bits visible");
        wr(12'h010, 3'd4, 32'h0000_8032, "R6 level write keeps RO bits");
        rd(12'h010, 3'd4, "R6 RO bits preserved");
        dlv_busy[0] = 0;
        wr(12'h010, 3'd4, 32'h0000_5033, "R6 write attempts RO bits");
        rd(12'h010, 3'd4, "R7 edge write clears pending");
        wr(12'h010, 3'd4, 32'h0000_8034, "R8 back to level");
        irr_set[0] = 1;
        wr(12'h010, 3'd4, 32'h0000_0035, "R11 set with same-cycle edge write");
        irr_set[0] = 0;
        rd(12'h010, 3'd4, "R7 edge wins over same-cycle set");
        irr_set[0] = 1;
        idle("R11 set again");
        irr_set[0] = 0; irr_clr[0] = 1;
        idle("R11 clear pending");
        irr_clr[0] = 0;
        rd(12'h010, 3'd4, "R11 pending cleared");
        // Range edges
        wr(12'h000, 3'd4, 32'h3F, "R5 select last entry high");
        wr(12'h010, 3'd4, 32'h1234_5678, "R5 last entry write");
        rd(12'h010, 3'd4, "R5 last entry read");
        wr(12'h000, 3'd4, 32'h3E, "R5 select last entry low");
        wr(12'h010, 3'd4, 32'h0000_9099, "R5 last entry low write");
        rd(12'h010, 3'd4, "R5 last entry low read");
        wr(12'h000, 3'd4, 32'h40, "R5 select past end");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R8 no rescan past end");
        rd(12'h010, 3'd4, "R5 past end reads zero");
        wr(12'h000, 3'd4, 32'h0F, "R5 select gap");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, "R8 no rescan in gap");
        rd(12'h010, 3'd4, "R5 gap reads zero");
        // EOI
        wr(12'h040, 3'd4, 32'h0000_0031, "R9 eoi forwarded");
        wr(12'h040, 3'd1, 32'h0000_0032, "R2 short eoi ignored");
        wr(12'hA40, 3'd4, 32'h0000_00FE, "R9 eoi with upper address bits");
        idle("R9 idle after eoi");
        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            int pick = $urandom_range(0, 9);
            bit [2:0] sz = ($urandom_range(0, 4) == 0) ? 3'd2 : 3'd4;
            irr_set  = NP'($urandom) & NP'($urandom);
            irr_clr  = NP'($urandom) & NP'($urandom) & NP'($urandom);
            dlv_busy = NP'($urandom);
            if (pick < 2) wr(12'h000, 3'd4, 32'($urandom_range(0, 72)), "R5 mixed select");
            else if (pick < 5) wr(12'h010, sz, $urandom, "R6 mixed window write");
            else if (pick < 8) rd(12'h010, sz, "R6 mixed window read");
            else if (pick < 9) wr(12'h040, sz, $urandom, "R9 mixed eoi");
            else idle("R11 mixed idle");
        end
        irr_set = 0; irr_clr = 0; dlv_busy = 0;
        idle("R8 final idle");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule